// File: doc/BRIEF.md
# Block Address Translation Matcher

This block translates 32-bit effective addresses through a small set of block-mapping entries. Each entry is a pair of 32-bit words: an upper word that says which effective region the entry covers, how large it is, and in which privilege modes it applies, and a lower word that gives the physical block base, four memory attribute bits and a two-bit protection code. Software loads the words one at a time through a plain write port.

A lookup presents an effective address, a user/supervisor flag and an access kind. Every entry is compared in parallel. The lowest-numbered matching entry supplies the physical address, the attribute bits and the read/write/execute rights. The block also raises a fault when the access kind is not permitted. The result is registered and appears one clock after the request. When no entry matches, the result reports a miss with all other fields zero.

Top module: `blk_xlate`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid`, `rsp_hit` and `rsp_miss` are 0, and any lookup misses.
- R2: A write with `cfg_we`=1 stores `cfg_data` into the upper word (`cfg_lower`=0) or the lower word (`cfg_lower`=1) of entry `cfg_idx`. Lookups issued in a later cycle see the new value. A lookup issued in the same cycle as the write sees the old contents.
- R3: The upper word layout is effective block index in bits 31:17, length mask in bits 12:2, supervisor-valid in bit 1 and user-valid in bit 0. Length-mask bit k (k=0..10) makes effective-address bit 17+k a don't-care, so bits 31:28 are always compared.
- R4: An entry matches when its valid bit for the current mode is set (`req_user`=1 selects bit 0, `req_user`=0 selects bit 1) and effective-address bits 31:17 equal the stored index in every position not masked by the length mask.
- R5: The lower word layout is physical block number in bits 31:17, attributes in bits 6:3 and protection code in bits 1:0. On a hit, `rsp_pa` bits 31:17 take the physical block number where unmasked and the effective address where masked, `rsp_pa` bits 16:0 equal the effective address, and `rsp_attr` equals lower-word bits 6:3.
- R6: Protection code 0 grants nothing. Codes 1 and 3 grant read and execute. Code 2 grants read, write and execute. The rights appear on `rsp_rd`, `rsp_wr` and `rsp_ex`.
- R7: When several entries match, the lowest-numbered one supplies the result.
- R8: On a miss, `rsp_miss`=1, `rsp_hit`=0, and `rsp_pa`, `rsp_attr`, the rights and `rsp_fault` are all 0.
- R9: `req_kind` encodes 0 load, 1 store, 2 fetch and 3 (treated as load). On a hit, `rsp_fault`=1 for a store without write, a fetch without execute, or a load without read.
- R10: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid`=1. Without a request, all result fields hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Entry word write strobe |
| cfg_idx | input | IDX_W | Entry number to write |
| cfg_lower | input | 1 | 1 selects lower word, 0 upper word |
| cfg_data | input | 32 | Word to store |
| req_valid | input | 1 | Lookup request |
| req_ea | input | 32 | Effective address |
| req_user | input | 1 | 1 user mode, 0 supervisor mode |
| req_kind | input | 2 | Access kind (0 load, 1 store, 2 fetch, 3 load) |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_hit | output | 1 | An entry matched |
| rsp_miss | output | 1 | No entry matched |
| rsp_pa | output | 32 | Physical address |
| rsp_attr | output | 4 | Memory attribute bits |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_ex | output | 1 | Execute permitted |
| rsp_fault | output | 1 | Access kind not permitted |

## Verification
The hardest situation to reach from the ports is a write and a lookup landing in the same cycle. The lookup must resolve against the entry's old contents. The bench drives both strobes on the same edge: it invalidates an entry that the simultaneous fetch still hits, checks the old rights and the fault, and then checks that the next lookup misses. Overlapping entries with different base addresses expose the priority order, and a length mask with all eleven bits set shows that only the top four address bits are compared.

// File: rtl/blkx_pkg.sv
package blkx_pkg;

    localparam int EA_W     = 32;
    localparam int PG_LSB   = 17;
    localparam int PG_W     = EA_W - PG_LSB;
    localparam int LEN_W    = 11;
    localparam int LEN_LSB  = 2;
    localparam int ATTR_W   = 4;
    localparam int ATTR_LSB = 3;
    localparam int SUP_BIT  = 1;
    localparam int USR_BIT  = 0;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_OTHER = 2'd3
    } acc_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } rights_t;

    // Two-bit protection code to rights: zero grants nothing, any other
    // code grants read and execute, and code 2 adds write.
    function automatic rights_t decode_prot(input logic [1:0] code);
        rights_t r;
        r.rd = (code != 2'd0);
        r.ex = (code != 2'd0);
        r.wr = (code == 2'd2);
        return r;
    endfunction

    // Length field widened to the page-index width; upper bits stay compared.
    function automatic logic [PG_W-1:0] len_to_mask(input logic [LEN_W-1:0] len);
        return {{(PG_W-LEN_W){1'b0}}, len};
    endfunction

endpackage

// File: rtl/blkx_regfile.sv
module blkx_regfile
    import blkx_pkg::*;
#(
    parameter int N_PAIRS = 4,
    parameter int IDX_W   = (N_PAIRS > 1) ? $clog2(N_PAIRS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [IDX_W-1:0]             cfg_idx,
    input  logic                         cfg_lower,
    input  logic [EA_W-1:0]              cfg_data,
    output logic [N_PAIRS-1:0][EA_W-1:0] upper_o,
    output logic [N_PAIRS-1:0][EA_W-1:0] lower_o
);

    typedef struct packed {
        logic [N_PAIRS-1:0][EA_W-1:0] up;
        logic [N_PAIRS-1:0][EA_W-1:0] lo;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (cfg_we && (int'(cfg_idx) < N_PAIRS)) begin
            if (cfg_lower) begin
                regs_d.lo[cfg_idx] = cfg_data;
            end else begin
                regs_d.up[cfg_idx] = cfg_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign upper_o = regs_q.up;
    assign lower_o = regs_q.lo;

    // R2
    cfg_upper_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_lower) |=> (upper_o[$past(cfg_idx)] == $past(cfg_data)));

    // R2
    cfg_lower_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_lower) |=> (lower_o[$past(cfg_idx)] == $past(cfg_data)));

endmodule

// File: rtl/blkx_match.sv
module blkx_match
    import blkx_pkg::*;
#(
    parameter int N_PAIRS = 4
) (
    input  logic [N_PAIRS-1:0][EA_W-1:0]   upper_i,
    input  logic [N_PAIRS-1:0][EA_W-1:0]   lower_i,
    input  logic [EA_W-1:0]                ea_i,
    input  logic                           user_i,
    output logic [N_PAIRS-1:0]             hit_o,
    output logic [N_PAIRS-1:0][EA_W-1:0]   pa_o,
    output logic [N_PAIRS-1:0][ATTR_W-1:0] attr_o,
    output logic [N_PAIRS-1:0][1:0]        prot_o
);

    logic [PG_W-1:0] ea_pg;
    assign ea_pg = ea_i[EA_W-1:PG_LSB];

    for (genvar g = 0; g < N_PAIRS; g++) begin : g_pair
        logic [PG_W-1:0] mask;
        logic [PG_W-1:0] index;
        logic [PG_W-1:0] base;
        logic            mode_ok;

        assign mask    = len_to_mask(upper_i[g][LEN_LSB +: LEN_W]);
        assign index   = upper_i[g][EA_W-1:PG_LSB];
        assign base    = lower_i[g][EA_W-1:PG_LSB];
        assign mode_ok = user_i ? upper_i[g][USR_BIT] : upper_i[g][SUP_BIT];

        assign hit_o[g]  = mode_ok && (((ea_pg ^ index) & ~mask) == '0);
        assign pa_o[g]   = {(base & ~mask) | (ea_pg & mask), ea_i[PG_LSB-1:0]};
        assign attr_o[g] = lower_i[g][ATTR_LSB +: ATTR_W];
        assign prot_o[g] = lower_i[g][1:0];
    end

endmodule

// File: rtl/blkx_pick.sv
module blkx_pick
    import blkx_pkg::*;
#(
    parameter int N_PAIRS = 4
) (
    input  logic [N_PAIRS-1:0]             hit_i,
    input  logic [N_PAIRS-1:0][EA_W-1:0]   pa_i,
    input  logic [N_PAIRS-1:0][ATTR_W-1:0] attr_i,
    input  logic [N_PAIRS-1:0][1:0]        prot_i,
    output logic                           any_o,
    output logic [N_PAIRS-1:0]             win_o,
    output logic [EA_W-1:0]                pa_o,
    output logic [ATTR_W-1:0]              attr_o,
    output logic [1:0]                     prot_o
);

    always_comb begin
        any_o  = 1'b0;
        win_o  = '0;
        pa_o   = '0;
        attr_o = '0;
        prot_o = '0;
        for (int i = 0; i < N_PAIRS; i++) begin
            if (hit_i[i] && !any_o) begin
                any_o     = 1'b1;
                win_o[i]  = 1'b1;
                pa_o      = pa_i[i];
                attr_o    = attr_i[i];
                prot_o    = prot_i[i];
            end
        end
    end

    always_comb begin
        if (!$isunknown(hit_i) && !$isunknown(win_o)) begin
            // R7
            win_onehot_chk: assert ($onehot0(win_o));
            // R7
            win_is_hit_chk: assert ((win_o & ~hit_i) == '0);
            // R7
            win_lowest_chk: assert (((win_o - 1'b1) & hit_i & {N_PAIRS{|win_o}}) == '0);
        end
    end

endmodule

// File: rtl/blk_xlate.sv
module blk_xlate
    import blkx_pkg::*;
#(
    parameter int N_PAIRS = 4,
    parameter int IDX_W   = (N_PAIRS > 1) ? $clog2(N_PAIRS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_lower,
    input  logic [31:0]       cfg_data,
    input  logic              req_valid,
    input  logic [31:0]       req_ea,
    input  logic              req_user,
    input  logic [1:0]        req_kind,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [31:0]       rsp_pa,
    output logic [3:0]        rsp_attr,
    output logic              rsp_rd,
    output logic              rsp_wr,
    output logic              rsp_ex,
    output logic              rsp_fault
);

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              miss;
        logic [EA_W-1:0]   pa;
        logic [ATTR_W-1:0] attr;
        rights_t           rights;
        logic              fault;
    } res_t;

    logic [N_PAIRS-1:0][EA_W-1:0]   upper_w, lower_w;
    logic [N_PAIRS-1:0]             hit_w, win_w;
    logic [N_PAIRS-1:0][EA_W-1:0]   pa_w;
    logic [N_PAIRS-1:0][ATTR_W-1:0] attr_w;
    logic [N_PAIRS-1:0][1:0]        prot_w;
    logic                           any_w;
    logic [EA_W-1:0]                sel_pa;
    logic [ATTR_W-1:0]              sel_attr;
    logic [1:0]                     sel_prot;

    res_t res_d, res_q;

    blkx_regfile #(.N_PAIRS(N_PAIRS), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_lower (cfg_lower),
        .cfg_data  (cfg_data),
        .upper_o   (upper_w),
        .lower_o   (lower_w)
    );

    blkx_match #(.N_PAIRS(N_PAIRS)) u_match (
        .upper_i (upper_w),
        .lower_i (lower_w),
        .ea_i    (req_ea),
        .user_i  (req_user),
        .hit_o   (hit_w),
        .pa_o    (pa_w),
        .attr_o  (attr_w),
        .prot_o  (prot_w)
    );

    blkx_pick #(.N_PAIRS(N_PAIRS)) u_pick (
        .hit_i  (hit_w),
        .pa_i   (pa_w),
        .attr_i (attr_w),
        .prot_i (prot_w),
        .any_o  (any_w),
        .win_o  (win_w),
        .pa_o   (sel_pa),
        .attr_o (sel_attr),
        .prot_o (sel_prot)
    );

    always_comb begin
        rights_t rts;
        logic    denied;
        res_d       = res_q;
        res_d.valid = req_valid;
        rts         = any_w ? decode_prot(sel_prot) : '0;
        unique case (acc_e'(req_kind))
            ACC_STORE: denied = !rts.wr;
            ACC_FETCH: denied = !rts.ex;
            default:   denied = !rts.rd;
        endcase
        if (req_valid) begin
            res_d.hit    = any_w;
            res_d.miss   = !any_w;
            res_d.pa     = any_w ? sel_pa : '0;
            res_d.attr   = any_w ? sel_attr : '0;
            res_d.rights = rts;
            res_d.fault  = any_w && denied;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign rsp_valid = res_q.valid;
    assign rsp_hit   = res_q.hit;
    assign rsp_miss  = res_q.miss;
    assign rsp_pa    = res_q.pa;
    assign rsp_attr  = res_q.attr;
    assign rsp_rd    = res_q.rights.rd;
    assign rsp_wr    = res_q.rights.wr;
    assign rsp_ex    = res_q.rights.ex;
    assign rsp_fault = res_q.fault;

    // R10
    rsp_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R10
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(rsp_pa) && $stable(rsp_hit)));

    // R8
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> (rsp_pa == '0 && rsp_attr == '0 && !rsp_rd
                                     && !rsp_wr && !rsp_ex && !rsp_fault && !rsp_hit));

    // R6
    wr_needs_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_wr) |-> (rsp_rd && rsp_ex));

    // R9
    fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> rsp_hit);

    // R5
    low_bits_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && any_w) |=> (rsp_pa[PG_LSB-1:0] == $past(req_ea[PG_LSB-1:0])));

endmodule

// File: tb/blk_xlate_tb.sv
module blk_xlate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic        cfg_lower = 1'b0;
    logic [31:0] cfg_data = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_ea = '0;
    logic        req_user = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_rd, rsp_wr, rsp_ex, rsp_fault;
    logic [31:0] rsp_pa;
    logic [3:0]  rsp_attr;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    blk_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_lower(cfg_lower), .cfg_data(cfg_data), .req_valid(req_valid),
        .req_ea(req_ea), .req_user(req_user), .req_kind(req_kind),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_pa(rsp_pa), .rsp_attr(rsp_attr), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr),
        .rsp_ex(rsp_ex), .rsp_fault(rsp_fault)
    );

    typedef struct packed {
        logic [31:0] ea;
        logic        user;
        logic [1:0]  kind;
        logic        hit;
        logic [31:0] pa;
        logic [3:0]  attr;
        logic [2:0]  rwx;
        logic        fault;
    } vec_t;

    // Entries: 0 sup-only 128K @0 -> 0x1000_0000 attr 5 code 2
    //          1 both 1M @0x4000_0000 -> 0x8000_0000 attr 8 code 1
    //          2 both 128K @0x4000_0000 -> 0x2222_0000 (shadowed by 1)
    //          3 user-only 128K @0x6000_0000 -> 0x3000_0000 code 3
    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{32'h0001_2345, 1'b0, 2'd0, 1'b1, 32'h1001_2345, 4'h5, 3'b111, 1'b0}, // R4 R5
        '{32'h0001_2345, 1'b1, 2'd0, 1'b0, 32'h0,         4'h0, 3'b000, 1'b0}, // R4 R8
        '{32'h0002_0000, 1'b0, 2'd0, 1'b0, 32'h0,         4'h0, 3'b000, 1'b0}, // R3 R8
        '{32'h400A_BCDE, 1'b0, 2'd1, 1'b1, 32'h800A_BCDE, 4'h8, 3'b101, 1'b1}, // R3 R9
        '{32'h400A_BCDE, 1'b1, 2'd2, 1'b1, 32'h800A_BCDE, 4'h8, 3'b101, 1'b0}, // R6 R9
        '{32'h4010_0000, 1'b0, 2'd0, 1'b0, 32'h0,         4'h0, 3'b000, 1'b0}, // R3
        '{32'h4001_0004, 1'b0, 2'd0, 1'b1, 32'h8001_0004, 4'h8, 3'b101, 1'b0}, // R7
        '{32'h6000_1000, 1'b1, 2'd1, 1'b1, 32'h3000_1000, 4'h0, 3'b101, 1'b1}, // R6 R9
        '{32'h6000_1000, 1'b0, 2'd0, 1'b0, 32'h0,         4'h0, 3'b000, 1'b0}, // R4
        '{32'h6000_1000, 1'b1, 2'd2, 1'b1, 32'h3000_1000, 4'h0, 3'b101, 1'b0}, // R9
        '{32'h0001_FFFF, 1'b0, 2'd2, 1'b1, 32'h1001_FFFF, 4'h5, 3'b111, 1'b0}  // R5
    };

    task automatic write_word(input logic [1:0] idx, input bit lo, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_lower = lo; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] ea, input bit user, input logic [1:0] kind);
        @(negedge clk);
        req_valid = 1'b1; req_ea = ea; req_user = user; req_kind = kind;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic check(input string tag, input bit hit, input logic [31:0] pa,
                         input logic [3:0] attr, input logic [2:0] rwx, input bit fault);
        nchk++;
        if (rsp_valid !== 1'b1 || rsp_hit !== hit || rsp_miss !== !hit || rsp_pa !== pa
            || rsp_attr !== attr || {rsp_rd, rsp_wr, rsp_ex} !== rwx || rsp_fault !== fault) begin
            nfail++;
            $display("FAIL %s: got v=%b hit=%b miss=%b pa=%h attr=%h rwx=%b fault=%b; exp v=1 hit=%b miss=%b pa=%h attr=%h rwx=%b fault=%b",
                     tag, rsp_valid, rsp_hit, rsp_miss, rsp_pa, rsp_attr,
                     {rsp_rd, rsp_wr, rsp_ex}, rsp_fault, hit, !hit, pa, attr, rwx, fault);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state at the ports
        @(negedge clk);
        nchk++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_miss !== 1'b0) begin
            nfail++;
            $display("FAIL R1 reset: got v=%b hit=%b miss=%b, exp 0 0 0", rsp_valid, rsp_hit, rsp_miss);
        end
        lookup(32'h0000_0000, 1'b0, 2'd0);
        check("R1 lookup after reset", 1'b0, 32'h0, 4'h0, 3'b000, 1'b0);

        write_word(2'd0, 1'b0, 32'h0000_0002);
        write_word(2'd0, 1'b1, 32'h1000_002A);
        write_word(2'd1, 1'b0, 32'h4000_001F);
        write_word(2'd1, 1'b1, 32'h8000_0041);
        write_word(2'd2, 1'b0, 32'h4000_0003);
        write_word(2'd2, 1'b1, 32'h2222_0002);
        write_word(2'd3, 1'b0, 32'h6000_0001);
        write_word(2'd3, 1'b1, 32'h3000_0003);

        for (int i = 0; i < NV; i++) begin
            lookup(VECS[i].ea, VECS[i].user, VECS[i].kind);
            check($sformatf("R4/R5 vector %0d", i), VECS[i].hit, VECS[i].pa,
                  VECS[i].attr, VECS[i].rwx, VECS[i].fault);
        end

        // R10: idle cycle drops valid, holds the last result
        @(negedge clk);
        nchk++;
        if (rsp_valid !== 1'b0 || rsp_pa !== 32'h1001_FFFF || rsp_hit !== 1'b1) begin
            nfail++;
            $display("FAIL R10 idle: got v=%b pa=%h hit=%b, exp v=0 pa=1001ffff hit=1",
                     rsp_valid, rsp_pa, rsp_hit);
        end

        // R6: code 0 grants nothing; R9 load and kind 3 both fault
        write_word(2'd0, 1'b1, 32'h1000_0028);
        lookup(32'h0000_0010, 1'b0, 2'd0);
        check("R6 code0 load", 1'b1, 32'h1000_0010, 4'h5, 3'b000, 1'b1);
        lookup(32'h0000_0010, 1'b0, 2'd3);
        check("R9 kind3 as load", 1'b1, 32'h1000_0010, 4'h5, 3'b000, 1'b1);

        // R3: full length mask leaves only bits 31:28 compared
        write_word(2'd3, 1'b0, 32'h6000_1FFF);
        lookup(32'h6FFF_F123, 1'b1, 2'd0);
        check("R3 full mask hit", 1'b1, 32'h3FFF_F123, 4'h0, 3'b101, 1'b0);
        lookup(32'h7000_0000, 1'b0, 2'd0);
        check("R3 full mask top nibble miss", 1'b0, 32'h0, 4'h0, 3'b000, 1'b0);

        // R2: write and lookup in the same cycle see old contents
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'd0; cfg_lower = 1'b0; cfg_data = 32'h0;
        req_valid = 1'b1; req_ea = 32'h0000_0010; req_user = 1'b0; req_kind = 2'd2;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check("R2 same-cycle old view", 1'b1, 32'h1000_0010, 4'h5, 3'b000, 1'b1);
        lookup(32'h0000_0010, 1'b0, 2'd0);
        check("R2 new view miss", 1'b0, 32'h0, 4'h0, 3'b000, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule